// File: doc/BRIEF.md
# Embedded-Clock Word Serializer

This block turns a parallel word, presented once per word clock period, into a serial stream on a bit clock that runs twelve times faster. Each word travels in a 12-bit slot that opens with a high marker bit and closes with a low marker bit. The fixed low-to-high step between one slot's closing bit and the next slot's opening bit is the timing edge a receiver recovers its clock from. The parallel word is registered in the word clock domain, on the edge that a select input picks, and reaches the bit clock domain through a multi-stage synchronizer. A framed word is loaded into a shift register at the start of every slot.

Two request inputs can replace the data with a training pattern: a run of high bits followed by a run of low bits in each slot. The pattern starts only after a request has been seen at several consecutive slot starts. It stops as soon as a slot starts with neither request present. The line is not driven until an external lock flag reports a usable bit clock. An output enable and an active-low power-down input also gate the driver. High impedance is shown by a low drive-enable output. The lock, power and enable inputs are synchronous to the bit clock.

Top module: `emb_serializer`

## Requirements
- R1: While `lock` is low, whether after reset or when it drops during operation, `ser_oe` and `ser_d` are 0 from the next bit clock edge on.
- R2: With `lock` and `pwr_on` high, slots of 12 bits follow each other back to back. Bit 0 in time is 1, bits 1 to 10 are `din[0]` to `din[9]` (least significant first), and bit 11 is 0. The first slot's opening bit appears after the first bit clock edge at which `lock` and `pwr_on` are both sampled high. A word held steady for two slot periods is carried by the next slot.
- R3: With `edge_rise` = 1 the word present at the rising edge of `clk_word` is sent. With `edge_rise` = 0 the word present at the falling edge is sent.
- R4: Requests are examined at each slot start after two bit-clock synchronizer stages. If a request is raised within the last bit period before a slot start, that slot and the next four still carry data, and the sixth carries the training pattern. While the pattern is sent, `din` is ignored.
- R5: The training pattern in a slot is six 1 bits followed by six 0 bits in transmission order, with `ser_oe` high.
- R6: Either `sync_req_a` alone or `sync_req_b` alone triggers the training pattern with the same timing.
- R7: If both requests are lowered within the last bit period before a slot start, that slot still carries the pattern and the next slot carries data. A slot start that sees no request clears the qualification, so a request raised again needs five fresh qualifying slot starts.
- R8: With `out_en` low, `ser_oe` is 0 from the next bit edge on while slot timing and content continue. Raising `out_en` restores driving with framing unchanged.
- R9: With `pwr_on` low, `ser_oe` and `ser_d` are 0, the slot timing is reset and the qualification count is cleared. When power returns, a slot opens on the first edge, and a request held throughout needs five slot starts again before the pattern is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock, twelve times the word rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_word | input | 1 | Word clock for the parallel input |
| edge_rise | input | 1 | 1: capture on rising edge, 0: on falling edge |
| din | input | 10 | Parallel data word |
| sync_req_a | input | 1 | Training pattern request, first input |
| sync_req_b | input | 1 | Training pattern request, second input |
| out_en | input | 1 | Output driver enable |
| pwr_on | input | 1 | Active-low power-down (1 = powered) |
| lock | input | 1 | Bit clock ready flag |
| ser_d | output | 1 | Serial data bit |
| ser_oe | output | 1 | Serial driver enable (0 = high impedance) |

## Verification
The bench uses the default parameters: a 10-bit word, five qualifying slot starts and two synchronizer stages. The 10-bit word lets every one of the 1024 values be sent through a rising-edge capture and compared bit by bit against a frame built arithmetically. A strided subset covers falling-edge capture. A word that changes every half word period makes the two capture edges yield distinct values. Because the qualification count is only five, the exact slot where the pattern starts, the interrupted-request restart and the power-down clear can all be pinned to single slots.

// File: rtl/ser_pkg.sv
package ser_pkg;

   typedef enum logic {
      SRC_DATA = 1'b0,
      SRC_SYNC = 1'b1
   } slot_src_e;

   // Mask with the n lowest bits set (n up to 63).
   function automatic logic [63:0] low_ones(input int n);
      low_ones = (64'd1 << n) - 64'd1;
   endfunction

endpackage

// File: rtl/ser_sync_chain.sv
module ser_sync_chain #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[k] <= '0;
            else        stg[k] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[k] <= '0;
            else        stg[k] <= stg[k-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/ser_word_capture.sv
module ser_word_capture #(
   parameter int WIDTH = 10
) (
   input  logic             clk_word,
   input  logic             rst_n,
   input  logic             edge_rise,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] cap
);

   logic [WIDTH-1:0] cap_pos;
   logic [WIDTH-1:0] cap_neg;

   always_ff @(posedge clk_word or negedge rst_n) begin
      if (!rst_n) cap_pos <= '0;
      else        cap_pos <= din;
   end

   always_ff @(negedge clk_word or negedge rst_n) begin
      if (!rst_n) cap_neg <= '0;
      else        cap_neg <= din;
   end

   assign cap = edge_rise ? cap_pos : cap_neg;

endmodule

// File: rtl/ser_sync_qual.sv
module ser_sync_qual #(
   parameter int HOLD = 5,
   parameter int QW   = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run,
   input  logic                 tick,
   input  logic                 req,
   output ser_pkg::slot_src_e   src,
   output logic [QW-1:0]        qcnt
);

   localparam logic [QW-1:0] HOLD_Q = QW'(HOLD);

   logic [QW-1:0] q_next;

   always_comb begin
      if (!req)                q_next = '0;
      else if (qcnt == HOLD_Q) q_next = HOLD_Q;
      else                     q_next = qcnt + 1'b1;
   end

   assign src = (q_next == HOLD_Q) ? ser_pkg::SRC_SYNC : ser_pkg::SRC_DATA;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    qcnt <= '0;
      else if (!run) qcnt <= '0;
      else if (tick) qcnt <= q_next;
   end

endmodule

// File: rtl/ser_shifter.sv
module ser_shifter #(
   parameter int FRAME_W = 12,
   parameter int CNT_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               drive_en,
   input  logic [FRAME_W-1:0] load_word,
   output logic [CNT_W-1:0]   slot_cnt,
   output logic               tick,
   output logic               ser_d,
   output logic               ser_oe
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

   logic [FRAME_W-1:0] sh;

   assign tick  = run && (slot_cnt == '0);
   assign ser_d = sh[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                slot_cnt <= '0;
      else if (!run)             slot_cnt <= '0;
      else if (slot_cnt == LAST) slot_cnt <= '0;
      else                       slot_cnt <= slot_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sh <= '0;
      else if (!run) sh <= '0;
      else if (tick) sh <= load_word;
      else           sh <= {1'b0, sh[FRAME_W-1:1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ser_oe <= 1'b0;
      else        ser_oe <= run && drive_en;
   end

endmodule

// File: rtl/emb_serializer.sv
module emb_serializer #(
   parameter int DATA_W      = 10,
   parameter int SYNC_HOLD   = 5,
   parameter int SYNC_STAGES = 2,
   parameter bit LSB_FIRST   = 1'b1
) (
   input  logic              clk_bit,
   input  logic              rst_n,
   input  logic              clk_word,
   input  logic              edge_rise,
   input  logic [DATA_W-1:0] din,
   input  logic              sync_req_a,
   input  logic              sync_req_b,
   input  logic              out_en,
   input  logic              pwr_on,
   input  logic              lock,
   output logic              ser_d,
   output logic              ser_oe
);

   localparam int FRAME_W = DATA_W + 2;
   localparam int CNT_W   = $clog2(FRAME_W);
   localparam int QW      = $clog2(SYNC_HOLD + 1);
   localparam int HALF    = FRAME_W / 2;
   localparam logic [FRAME_W-1:0] SYNC_PAT = FRAME_W'(ser_pkg::low_ones(HALF));

   if (DATA_W < 1 || FRAME_W > 63) begin : g_bad_width
      $error("emb_serializer: DATA_W out of range");
   end
   if (SYNC_HOLD < 1) begin : g_bad_hold
      $error("emb_serializer: SYNC_HOLD must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("emb_serializer: SYNC_STAGES must be at least 2");
   end

   logic                run;
   logic                tick;
   logic [CNT_W-1:0]    slot_cnt;
   logic [DATA_W-1:0]   cap;
   logic [DATA_W-1:0]   data_s;
   logic [DATA_W-1:0]   ord;
   logic [0:0]          req_raw;
   logic [0:0]          req_sv;
   logic                req_s;
   logic [QW-1:0]       qcnt;
   ser_pkg::slot_src_e  src;
   logic [FRAME_W-1:0]  data_frame;
   logic [FRAME_W-1:0]  load_word;

   assign run     = lock && pwr_on;
   assign req_raw = sync_req_a | sync_req_b;
   assign req_s   = req_sv[0];

   ser_word_capture #(.WIDTH(DATA_W)) u_cap (
      .clk_word  (clk_word),
      .rst_n     (rst_n),
      .edge_rise (edge_rise),
      .din       (din),
      .cap       (cap)
   );

   ser_sync_chain #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_data_sync (
      .clk   (clk_bit),
      .rst_n (rst_n),
      .d     (cap),
      .q     (data_s)
   );

   ser_sync_chain #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_req_sync (
      .clk   (clk_bit),
      .rst_n (rst_n),
      .d     (req_raw),
      .q     (req_sv)
   );

   ser_sync_qual #(.HOLD(SYNC_HOLD), .QW(QW)) u_qual (
      .clk   (clk_bit),
      .rst_n (rst_n),
      .run   (run),
      .tick  (tick),
      .req   (req_s),
      .src   (src),
      .qcnt  (qcnt)
   );

   if (LSB_FIRST) begin : g_lsb_first
      assign ord = data_s;
   end else begin : g_msb_first
      for (genvar i = 0; i < DATA_W; i++) begin : g_rev
         assign ord[i] = data_s[DATA_W-1-i];
      end
   end

   assign data_frame = {1'b0, ord, 1'b1};
   assign load_word  = (src == ser_pkg::SRC_SYNC) ? SYNC_PAT : data_frame;

   ser_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
      .clk       (clk_bit),
      .rst_n     (rst_n),
      .run       (run),
      .drive_en  (out_en),
      .load_word (load_word),
      .slot_cnt  (slot_cnt),
      .tick      (tick),
      .ser_d     (ser_d),
      .ser_oe    (ser_oe)
   );

endmodule

// File: rtl/ser_chk.sv
module ser_chk #(
   parameter int CNT_W   = 4,
   parameter int QW      = 3,
   parameter int FRAME_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lock,
   input logic             pwr_on,
   input logic             out_en,
   input logic             run,
   input logic             tick,
   input logic [CNT_W-1:0] slot_cnt,
   input logic             req_s,
   input logic [QW-1:0]    qcnt,
   input logic             ser_d,
   input logic             ser_oe
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

   AST_NO_DRIVE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !lock |=> !ser_oe); // R1

   AST_PWRDN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_on |=> (!ser_oe && !ser_d)); // R9

   AST_OE_FOLLOWS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en |=> !ser_oe); // R8

   AST_OPEN_BIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> ser_d); // R2

   AST_CLOSE_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (run && slot_cnt == LAST) |=> !ser_d); // R2

   AST_QUAL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !req_s) |=> (qcnt == '0)); // R7

endmodule

bind emb_serializer ser_chk #(
   .CNT_W   (CNT_W),
   .QW      (QW),
   .FRAME_W (FRAME_W)
) u_ser_chk (
   .clk      (clk_bit),
   .rst_n    (rst_n),
   .lock     (lock),
   .pwr_on   (pwr_on),
   .out_en   (out_en),
   .run      (run),
   .tick     (tick),
   .slot_cnt (slot_cnt),
   .req_s    (req_s),
   .qcnt     (qcnt),
   .ser_d    (ser_d),
   .ser_oe   (ser_oe)
);

// File: tb/tb_emb_serializer.sv
module tb_emb_serializer;

   localparam int BIT_P  = 10;
   localparam int WORD_H = 6 * BIT_P;
   localparam logic [11:0] PAT = 12'h03F;

   logic       clk_bit = 1'b0;
   logic       clk_word = 1'b0;
   logic       rst_n = 1'b0;
   logic       edge_rise = 1'b1;
   logic [9:0] din_main = '0;
   logic [9:0] alt_val = '0;
   logic [9:0] alt_a = 10'h155;
   logic [9:0] alt_b = 10'h2AA;
   logic       alt_on = 1'b0;
   logic [9:0] din;
   logic       sync_req_a = 1'b0;
   logic       sync_req_b = 1'b0;
   logic       out_en = 1'b1;
   logic       pwr_on = 1'b1;
   logic       lock = 1'b0;
   logic       ser_d;
   logic       ser_oe;

   int n_chk = 0;
   int n_err = 0;

   assign din = alt_on ? alt_val : din_main;

   always #(BIT_P/2) clk_bit = ~clk_bit;
   always #(WORD_H)  clk_word = ~clk_word;

   // Half-period alternating word: A while clk_word high, B while low.
   initial begin
      forever begin
         @(posedge clk_word); #1; alt_val = alt_a;
         @(negedge clk_word); #1; alt_val = alt_b;
      end
   end

   emb_serializer dut (
      .clk_bit    (clk_bit),
      .rst_n      (rst_n),
      .clk_word   (clk_word),
      .edge_rise  (edge_rise),
      .din        (din),
      .sync_req_a (sync_req_a),
      .sync_req_b (sync_req_b),
      .out_en     (out_en),
      .pwr_on     (pwr_on),
      .lock       (lock),
      .ser_d      (ser_d),
      .ser_oe     (ser_oe)
   );

   function automatic logic [11:0] frame_of(input logic [9:0] v);
      return {1'b0, v, 1'b1};
   endfunction

   task automatic read_slot(output logic [11:0] bits, output logic oe_all,
                            output logic oe_none);
      oe_all  = 1'b1;
      oe_none = 1'b1;
      for (int i = 0; i < 12; i++) begin
         @(posedge clk_bit); #1;
         bits[i] = ser_d;
         if (ser_oe) oe_none = 1'b0;
         else        oe_all  = 1'b0;
      end
   endtask

   task automatic skip_slots(input int n);
      for (int i = 0; i < 12 * n; i++) begin
         @(posedge clk_bit); #1;
      end
   endtask

   task automatic check_slot(input string req, input logic [11:0] exp);
      logic [11:0] b;
      logic oa, on;
      read_slot(b, oa, on);
      n_chk++;
      if (b !== exp || !oa) begin
         n_err++;
         $display("FAIL %s: slot=%h oe_all=%b expected slot=%h oe_all=1",
                  req, b, oa, exp);
      end
   endtask

   task automatic check_quiet(input string req);
      logic [11:0] b;
      logic oa, on;
      read_slot(b, oa, on);
      n_chk++;
      if (b !== 12'h000 || !on) begin
         n_err++;
         $display("FAIL %s: slot=%h oe_none=%b expected slot=000 oe_none=1",
                  req, b, on);
      end
   endtask

   initial begin
      #(BIT_P * 200000);
      n_err++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [11:0] b;
      logic oa, on;
      logic quiet;

      repeat (4) @(posedge clk_bit);
      #1 rst_n = 1'b1;

      // R1: not driven before lock
      quiet = 1'b1;
      din_main = 10'h2A5;
      for (int i = 0; i < 30; i++) begin
         @(posedge clk_bit); #1;
         if (ser_oe !== 1'b0 || ser_d !== 1'b0) quiet = 1'b0;
      end
      n_chk++;
      if (!quiet) begin
         n_err++;
         $display("FAIL R1: driven before lock, expected oe=0 d=0");
      end

      // R2: first slot opens on the first locked edge
      lock = 1'b1;
      check_slot("R2 first slot", frame_of(10'h2A5));

      // R2: exhaustive sweep, rising-edge capture
      for (int v = 0; v < 1024; v++) begin
         din_main = 10'(v);
         skip_slots(2);
         check_slot("R2 sweep", frame_of(10'(v)));
      end

      // R3: falling-edge capture, strided values
      edge_rise = 1'b0;
      for (int v = 0; v < 128; v++) begin
         din_main = 10'(v * 8 + 3);
         skip_slots(2);
         check_slot("R3 falling sweep", frame_of(10'(v * 8 + 3)));
      end

      // R3: half-period alternating word separates the two edges
      alt_on = 1'b1;
      edge_rise = 1'b1;
      skip_slots(3);
      check_slot("R3 rising picks low-phase word", frame_of(alt_b));
      edge_rise = 1'b0;
      skip_slots(2);
      check_slot("R3 falling picks high-phase word", frame_of(alt_a));
      alt_on = 1'b0;
      edge_rise = 1'b1;

      // R4, R5: qualification on request A, din ignored during pattern
      din_main = 10'h0F0;
      skip_slots(2);
      sync_req_a = 1'b1;
      for (int k = 0; k < 5; k++) check_slot("R4 data before qualify", frame_of(10'h0F0));
      din_main = 10'h3C3;
      check_slot("R5 training pattern", PAT);
      check_slot("R4 din ignored", PAT);
      check_slot("R4 din ignored", PAT);
      // R7: release
      sync_req_a = 1'b0;
      check_slot("R7 pattern in release slot", PAT);
      check_slot("R7 data after release", frame_of(10'h3C3));

      // R6: request B alone
      sync_req_b = 1'b1;
      for (int k = 0; k < 5; k++) check_slot("R6 data before qualify", frame_of(10'h3C3));
      check_slot("R6 pattern from request B", PAT);
      sync_req_b = 1'b0;
      check_slot("R6 pattern in release slot", PAT);
      check_slot("R6 data after release", frame_of(10'h3C3));

      // R7: a single clear slot start restarts qualification
      sync_req_a = 1'b1;
      for (int k = 0; k < 4; k++) check_slot("R7 data pre-gap", frame_of(10'h3C3));
      sync_req_a = 1'b0;
      check_slot("R7 data at gap", frame_of(10'h3C3));
      sync_req_a = 1'b1;
      for (int k = 0; k < 5; k++) check_slot("R7 data after restart", frame_of(10'h3C3));
      check_slot("R7 pattern after fresh qualify", PAT);
      sync_req_a = 1'b0;
      check_slot("R7 release slot", PAT);
      check_slot("R7 data", frame_of(10'h3C3));

      // R8: enable low stops driving, framing continues
      out_en = 1'b0;
      read_slot(b, oa, on);
      n_chk++;
      if (!on || b !== frame_of(10'h3C3)) begin
         n_err++;
         $display("FAIL R8: slot=%h oe_none=%b expected slot=%h oe_none=1",
                  b, on, frame_of(10'h3C3));
      end
      out_en = 1'b1;
      check_slot("R8 driving restored", frame_of(10'h3C3));

      // R1: lock drop during operation
      lock = 1'b0;
      check_quiet("R1 lock dropped");
      lock = 1'b1;
      check_slot("R1 relock", frame_of(10'h3C3));

      // R9: power-down clears timing and qualification
      sync_req_a = 1'b1;
      skip_slots(5);
      check_slot("R9 pattern before power-down", PAT);
      pwr_on = 1'b0;
      check_quiet("R9 powered down");
      for (int i = 0; i < 5; i++) begin
         @(posedge clk_bit); #1;
      end
      pwr_on = 1'b1;
      check_slot("R9 data after power-up", frame_of(10'h3C3));
      for (int k = 0; k < 3; k++) check_slot("R9 data while requalifying", frame_of(10'h3C3));
      check_slot("R9 pattern after requalify", PAT);
      sync_req_a = 1'b0;
      skip_slots(2);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule